// File: doc/BRIEF.md
# Lossy Occupancy-Counted Queue

This block is a first-in first-out queue placed between a producer and a consumer. An item counter tracks how many entries it holds. From that counter the queue derives three levels: empty, partly filled and full. Both ends use a valid/ready handshake. A producer that writes while the queue is full and no slot frees in that cycle does not stall. The word is thrown away, and a sticky overflow flag goes high and stays high until reset. This makes an undersized buffer visible instead of hiding it behind backpressure.

A lossy mode can be switched on to emulate a channel with a known, evenly spread loss rate. A loss counter counts the entries handed to the consumer. Once it has seen `DROP_EVERY-1` deliveries, the next head entry is removed without being offered, and a one-cycle drop pulse is raised. With the default of 5, one entry in five is lost, and losses never come in bursts.

Top module: `lossy_occ_queue`

## Requirements
- R1: `q_empty` is high exactly when the queue holds no entry. `q_nonempty` is high exactly when it holds at least one. `q_full` is high exactly when it holds `DEPTH` entries. `q_empty` and `q_nonempty` are never high together.
- R2: Entries reach `rd_data` in the order they were accepted. `rd_valid` is high whenever an entry is at the head and no drop is taking place.
- R3: The entry count never exceeds `DEPTH`. `wr_ready` is low when the queue is full and no entry leaves in that cycle.
- R4: A write (`wr_valid` high, `wr_ready` low) sets `overflow` in the next cycle. The written word is discarded.
- R5: `overflow` stays high until reset. Entries stored before the overflow remain readable in order.
- R6: A read and a write in the same cycle while full are both accepted, and `overflow` does not rise.
- R7: With `lossy_en` high, after `DROP_EVERY-1` deliveries the next head entry is discarded. In that cycle `rd_valid` is low and `drop_pulse` is high, and the count falls by one. The loss count then restarts from zero, so two drops never fall in adjacent cycles when `DROP_EVERY` is at least 2.
- R8: With `lossy_en` low, no entry is dropped, `drop_pulse` stays low and the loss count is held at zero.
- R9: After reset the queue is empty, `overflow` is low and `drop_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lossy_en | input | 1 | Enables periodic discard of entries |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | A slot is free in this cycle |
| wr_data | input | WIDTH | Word offered by the producer |
| rd_valid | output | 1 | Head entry is offered to the consumer |
| rd_ready | input | 1 | Consumer takes the head entry |
| rd_data | output | WIDTH | Head entry |
| q_empty | output | 1 | Queue holds no entry |
| q_nonempty | output | 1 | Queue holds at least one entry |
| q_full | output | 1 | Queue holds DEPTH entries |
| overflow | output | 1 | Sticky: a write was refused while full |
| drop_pulse | output | 1 | An entry is being discarded this cycle |

## Verification
The item counter, the pointers and the loss counter are internal state, and each one shows at the ports within a cycle or two when it goes wrong. A count that slips shows up in `q_full` or `q_empty` at the next edge. It also shows later as `wr_ready` refusing too early or too late, and hence as a false or missing `overflow`. A pointer error shows as the wrong `rd_data` at the very next delivery. A loss counter that is off by one moves the gap in the delivered sequence, or a `drop_pulse`, one entry away from where the bench model expects it.

// File: rtl/lq_pkg.sv
// Shared types for the lossy occupancy-counted queue.
package lq_pkg;

    // Fill level derived from the entry counter.
    typedef enum logic [1:0] {
        LQ_EMPTY   = 2'd0,
        LQ_PARTIAL = 2'd1,
        LQ_FULL    = 2'd2
    } lq_level_t;

endpackage

// File: rtl/lq_occupancy.sv
// Entry counter and fill level.
// Assumes push is only asserted when a slot is free or pop is asserted,
// and pop only when at least one entry is held.
module lq_occupancy #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    output logic [CW-1:0]     count,
    output lq_pkg::lq_level_t level
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // Count up on push, down on pop, hold when both or neither.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (push && !pop)
            count <= count + 1'b1;
        else if (pop && !push)
            count <= count - 1'b1;
    end

    // Map the count onto the three fill levels.
    always_comb begin
        if (count == '0)
            level = lq_pkg::LQ_EMPTY;
        else if (count == FULL_CNT)
            level = lq_pkg::LQ_FULL;
        else
            level = lq_pkg::LQ_PARTIAL;
    end
endmodule

// File: rtl/lq_store.sv
// Circular storage with separate write and read pointers.
// Assumes the caller never pushes into a full store without a pop in the
// same cycle; the head word is read combinationally.
module lq_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;

    // Step a pointer with wrap at the last slot.
    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    // Advance the pointers on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= step_ptr(wptr);
            if (pop)  rptr <= step_ptr(rptr);
        end
    end

    // Write the incoming word into its slot.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    // Present the head word.
    assign rd_data = mem[rptr];
endmodule

// File: rtl/lq_loss_sched.sv
// Loss scheduler: counts deliveries and marks every DROP_EVERY-th head
// entry for discard. Assumes deliver and drop never coincide, which the
// top guarantees by withholding rd_valid during a drop.
module lq_loss_sched #(
    parameter int DROP_EVERY = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lossy_en,
    input  logic head_avail,
    input  logic deliver,
    output logic drop
);
    generate
        if (DROP_EVERY <= 1) begin : g_drop_all
            // Every entry is lost; no counter needed.
            assign drop = lossy_en && head_avail;
        end else begin : g_counted
            localparam int LW = $clog2(DROP_EVERY);
            localparam logic [LW-1:0] LAST = LW'(DROP_EVERY - 1);

            logic [LW-1:0] seen;

            // Track deliveries since the last discard; cleared when off.
            always_ff @(posedge clk) begin
                if (!rst_n || !lossy_en)
                    seen <= '0;
                else if (drop)
                    seen <= '0;
                else if (deliver)
                    seen <= seen + 1'b1;
            end

            // Discard the head once the delivery quota is met.
            assign drop = lossy_en && head_avail && (seen == LAST);
        end
    endgenerate
endmodule

// File: rtl/lossy_occ_queue.sv
// Top of the lossy occupancy-counted queue. A write while full with no
// entry leaving is discarded and latches a sticky overflow flag.
// Assumes DEPTH >= 1 and a single clock domain.
module lossy_occ_queue #(
    parameter int DEPTH      = 8,
    parameter int WIDTH      = 16,
    parameter int DROP_EVERY = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lossy_en,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [WIDTH-1:0] wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [WIDTH-1:0] rd_data,
    output logic             q_empty,
    output logic             q_nonempty,
    output logic             q_full,
    output logic             overflow,
    output logic             drop_pulse
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]     count;
    lq_pkg::lq_level_t level;
    logic              drop;
    logic              deliver;
    logic              pop;
    logic              push;
    logic              head_avail;

    // Level decode to status pins.
    assign q_empty    = (level == lq_pkg::LQ_EMPTY);
    assign q_full     = (level == lq_pkg::LQ_FULL);
    assign q_nonempty = !q_empty;
    assign head_avail = q_nonempty;

    // Handshake and removal decisions.
    assign rd_valid   = head_avail && !drop;
    assign deliver    = rd_valid && rd_ready;
    assign pop        = deliver || drop;
    assign wr_ready   = !q_full || pop;
    assign push       = wr_valid && wr_ready;
    assign drop_pulse = drop;

    lq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .count (count),
        .level (level)
    );

    lq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    lq_loss_sched #(.DROP_EVERY(DROP_EVERY)) u_loss (
        .clk        (clk),
        .rst_n      (rst_n),
        .lossy_en   (lossy_en),
        .head_avail (head_avail),
        .deliver    (deliver),
        .drop       (drop)
    );

    // Latch overflow on a refused write; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (wr_valid && !wr_ready)
            overflow <= 1'b1;
    end
endmodule

// File: rtl/lq_checker.sv
// Port-level properties of the lossy queue, bound to the top.
module lq_checker #(
    parameter int DROP_EVERY = 5
) (
    input logic clk,
    input logic rst_n,
    input logic lossy_en,
    input logic wr_valid,
    input logic wr_ready,
    input logic rd_valid,
    input logic rd_ready,
    input logic q_empty,
    input logic q_nonempty,
    input logic q_full,
    input logic overflow,
    input logic drop_pulse
);
    assert_level_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_empty && q_nonempty) && (q_full -> q_nonempty));

    assert_empty_no_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> !rd_valid);

    assert_overflow_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(wr_valid && !wr_ready));

    assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_full_rw_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && rd_valid && rd_ready && wr_valid && !overflow) |=> !overflow);

    assert_drop_hides_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> (!rd_valid && q_nonempty));

    assert_drop_spaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse && (DROP_EVERY > 1)) |=> !drop_pulse);

    assert_no_drop_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lossy_en |-> !drop_pulse);
endmodule

bind lossy_occ_queue lq_checker #(.DROP_EVERY(DROP_EVERY)) u_lq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lossy_en   (lossy_en),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .q_empty    (q_empty),
    .q_nonempty (q_nonempty),
    .q_full     (q_full),
    .overflow   (overflow),
    .drop_pulse (drop_pulse)
);

// File: tb/tb_lossy_occ_queue.sv
module tb_lossy_occ_queue;
    localparam int DEPTH = 8;
    localparam int WIDTH = 16;
    localparam int NDROP = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lossy_en = 1'b0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             q_empty, q_nonempty, q_full, overflow, drop_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Bench model state.
    logic [WIDTH-1:0] mq [$];
    int  m_seen = 0;
    bit  m_ovf = 1'b0;
    logic [WIDTH-1:0] got [$];

    always #2 clk = ~clk;

    lossy_occ_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DROP_EVERY(NDROP)) dut (
        .clk(clk), .rst_n(rst_n), .lossy_en(lossy_en),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .q_empty(q_empty), .q_nonempty(q_nonempty), .q_full(q_full),
        .overflow(overflow), .drop_pulse(drop_pulse)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected drop decision from the requirements (R7, R8).
    function automatic bit exp_drop(input bit le, input int seen, input int n);
        return le && (n > 0) && (seen == NDROP - 1);
    endfunction

    // Expected write acceptance (R3).
    function automatic bit exp_wready(input int n, input bit popping);
        return (n < DEPTH) || popping;
    endfunction

    // One cycle: drive, compare, advance the model.
    task automatic step(input bit wv, input logic [WIDTH-1:0] wd, input bit rr, input bit le);
        bit d, rv, pp, wrd, ps;
        int n;
        @(negedge clk);
        wr_valid = wv; wr_data = wd; rd_ready = rr; lossy_en = le;
        #1;
        n  = mq.size();
        d  = exp_drop(le, m_seen, n);
        rv = (n > 0) && !d;
        pp = (rv && rr) || d;
        wrd = exp_wready(n, pp);
        ps = wv && wrd;
        chk("R1", "q_empty", q_empty, n == 0);
        chk("R1", "q_nonempty", q_nonempty, n > 0);
        chk("R1", "q_full", q_full, n == DEPTH);
        chk("R2", "rd_valid", rd_valid, rv);
        if (rv) chk("R2", "rd_data", rd_data, mq[0]);
        chk("R3", "wr_ready", wr_ready, wrd);
        chk("R5", "overflow", overflow, m_ovf);
        chk(le ? "R7" : "R8", "drop_pulse", drop_pulse, d);
        if (wv && !wrd) m_ovf = 1'b1;
        if (rv && rr) begin
            got.push_back(mq[0]);
            m_seen++;
        end
        if (pp) void'(mq.pop_front());
        if (d || !le) m_seen = 0;
        if (ps) mq.push_back(wd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0; lossy_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mq.delete(); got.delete();
        m_seen = 0; m_ovf = 1'b0;
        #1;
        chk("R9", "reset q_empty", q_empty, 1);
        chk("R9", "reset overflow", overflow, 0);
        chk("R9", "reset drop_pulse", drop_pulse, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R4/R5: fill, overflow, drain in order.
        for (int i = 0; i < DEPTH; i++) step(1, WIDTH'(16'h100 + i), 0, 0);
        step(1, 16'hDEAD, 0, 0);
        step(0, 0, 0, 0);
        chk("R4", "overflow after refused write", overflow, 1);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0);
        chk("R5", "drained count", got.size(), DEPTH);
        for (int i = 0; i < DEPTH; i++) chk("R5", "drained order", got[i], 16'h100 + i);
        step(0, 0, 0, 0);
        chk("R5", "overflow still set", overflow, 1);

        // R6: read and write together while full.
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, WIDTH'(i), 0, 0);
        step(1, 16'h55, 1, 0);
        step(0, 0, 0, 0);
        chk("R6", "no overflow on full read+write", overflow, 0);
        chk("R6", "still full", q_full, 1);

        // R7: lossy drain skips element 4.
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, WIDTH'(i), 0, 1);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 1);
        chk("R7", "delivered count", got.size(), DEPTH - 1);
        begin
            int expv [7] = '{0, 1, 2, 3, 5, 6, 7};
            for (int i = 0; i < 7; i++) chk("R7", "delivered value", got[i], expv[i]);
        end

        // Random phases: lossy on, off, and toggling.
        do_reset();
        for (int c = 0; c < 3000; c++) begin
            bit le;
            le = (c < 1000) ? 1'b1 : (c < 2000) ? 1'b0 : 1'($urandom_range(0, 1));
            step(($urandom_range(0, 99) < 55), WIDTH'($urandom), ($urandom_range(0, 99) < 50), le);
        end
        finished = 1'b1;
    end

    initial begin
        fork
            begin wait (finished); end
            begin
                repeat (100000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule